// File: doc/BRIEF.md
# Serial-Triggered Calibration Sequencer

This block is the digital control side of a converter's calibration. A host shifts a 24-bit word in on a serial clock. The word carries an 8-bit register address followed by 16 data bits. When the last serial clock of the word falls, the word takes effect. If it targets the configuration register, its low five data bits are loaded: one enable bit and a 4-bit select code.

After every completed transfer, the block looks at the configuration. This happens whichever register the transfer addressed. If the enable bit is set and the select code is one of the five listed codes, a calibration starts, timed on the master clock. For its whole length, `drdy_o` is held high. `drdy_o` drops in the cycle the run ends. In that same cycle, `upd_o` pulses for one cycle with a flag for each calibration register the run updated.

The enable bit stays set until a configuration write clears it. So with the enable bit left on, even a transfer to an unrelated register restarts the selected calibration. Transfers made while a calibration is running are not supported.

Top module: `cal_sequencer`

## Requirements
- R1: After reset `drdy_o` is 0 and `upd_o` is 0.
- R2: A transfer is 24 bits sampled on rising `sclk_i`, most significant bit first. Bits [23:16] are the address and bits [15:0] the data. The word takes effect on the falling edge of the 24th `sclk_i`.
- R3: A transfer to address `CFG_ADDR` (default 8'h00) loads the enable bit from data bit 4 and the select code from data bits 3:0. Data bits 15:5 have no effect.
- R4: With the enable bit at 1, the select codes map to the `upd_o` mask as follows: 4'b1000 gives 4'b0001 (reference non-ratiometric offset), 4'b0100 gives 4'b0010 (input non-ratiometric offset), 4'b0010 gives 4'b0100 (input ratiometric offset), 4'b0001 gives 4'b1000 (input gain), and 4'b1100 gives 4'b0011 (both non-ratiometric offsets).
- R5: A run with select 4'b0010 holds `drdy_o` high for exactly `DUR_LONG` master-clock cycles. Every other run holds it high for exactly `DUR_SHORT` cycles.
- R6: `drdy_o` rises no more than 4 master-clock cycles after the falling edge of the 24th `sclk_i`.
- R7: `upd_o` carries the run's mask for exactly one cycle, in the cycle `drdy_o` falls. Otherwise it is 0.
- R8: While the enable bit is set, a completed transfer to any other address restarts the selected calibration.
- R9: A configuration write with the enable bit at 0 starts no run, and its select bits are ignored. A later transfer to any address then also starts no run. `drdy_o` stays unchanged.
- R10: A configuration write with the enable bit at 1 and an unlisted select code starts no run and leaves `drdy_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| sclk_i | input | 1 | Serial clock, idle low |
| sdi_i | input | 1 | Serial data, sampled on rising `sclk_i` |
| drdy_o | output | 1 | High while a calibration runs |
| upd_o | output | 4 | One-cycle flags of calibration registers updated |

## Verification
The case hardest to reach from the ports is a restart caused by a transfer that never touches the configuration register. To get there, the enable bit must already be set from an earlier configuration write, and that earlier run must have finished. The stimulus table orders its entries to build this up: a valid configuration write first, then writes to other addresses, then disabling and unlisted codes. For each entry, the high time of `drdy_o` is counted cycle by cycle and the `upd_o` pulse is checked in the cycle `drdy_o` falls.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef struct packed {
    logic       ok;
    logic       long_run;
    logic [3:0] mask;
  } cal_dec_t;

  function automatic cal_dec_t cal_decode(input logic [3:0] sel);
    cal_dec_t d;
    d = '0;
    unique case (sel)
      4'b1000: d = '{ok: 1'b1, long_run: 1'b0, mask: 4'b0001};
      4'b0100: d = '{ok: 1'b1, long_run: 1'b0, mask: 4'b0010};
      4'b0010: d = '{ok: 1'b1, long_run: 1'b1, mask: 4'b0100};
      4'b0001: d = '{ok: 1'b1, long_run: 1'b0, mask: 4'b1000};
      4'b1100: d = '{ok: 1'b1, long_run: 1'b0, mask: 4'b0011};
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cal_serial_rx.sv
module cal_serial_rx #(
  parameter int WORD_W = 24
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              tog_o
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic              last_q;

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q   <= '0;
      bit_cnt_q <= '0;
      last_q    <= 1'b0;
    end else begin
      shift_q <= {shift_q[WORD_W-2:0], sdi_i};
      last_q  <= (bit_cnt_q == CNT_W'(WORD_W-1));
      if (bit_cnt_q == CNT_W'(WORD_W-1)) bit_cnt_q <= '0;
      else                               bit_cnt_q <= bit_cnt_q + 1'b1;
    end
  end

  // latch on the falling edge that closes the last bit
  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      tog_o  <= 1'b0;
    end else if (last_q) begin
      word_o <= shift_q;
      tog_o  <= ~tog_o;
    end
  end

  a_r2_bit_cnt_range: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    bit_cnt_q < CNT_W'(WORD_W));

endmodule

// File: rtl/cal_evt_sync.sv
module cal_evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tog_i,
  output logic evt_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tog_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign evt_o = sync_q[STAGES-1] ^ prev_q;

  // transfers are far apart relative to clk_i
  a_r6_evt_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);

endmodule

// File: rtl/cal_timer.sv
module cal_timer #(
  parameter int CNT_W = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= load_i;
      busy_o <= 1'b1;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done_o = busy_o && (cnt_q == '0);

  a_r5_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q != '0 && !start_i) |=> (busy_o && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer #(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 16,
  parameter logic [7:0]  CFG_ADDR  = 8'h00,
  parameter int          EN_BIT    = 4,
  parameter int          DUR_SHORT = 573440,
  parameter int          DUR_LONG  = 2211840
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       sdi_i,
  output logic       drdy_o,
  output logic [3:0] upd_o
);
  import cal_seq_pkg::*;

  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int DUR_MAX = (DUR_LONG > DUR_SHORT) ? DUR_LONG : DUR_SHORT;
  localparam int CNT_W  = $clog2(DUR_MAX + 1);

  logic [WORD_W-1:0] word;
  logic              tog, evt;
  logic              busy, done;

  logic              en_q;
  logic [3:0]        sel_q;
  logic [3:0]        mask_q;

  logic              is_cfg, nxt_en, start;
  logic [3:0]        nxt_sel;
  cal_dec_t          dec;
  logic [CNT_W-1:0]  load;

  cal_serial_rx #(.WORD_W(WORD_W)) u_rx (
    .sclk_i (sclk_i),
    .rst_ni (rst_ni),
    .sdi_i  (sdi_i),
    .word_o (word),
    .tog_o  (tog)
  );

  cal_evt_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tog_i  (tog),
    .evt_o  (evt)
  );

  always_comb begin
    is_cfg  = (word[WORD_W-1 -: ADDR_W] == ADDR_W'(CFG_ADDR));
    nxt_en  = is_cfg ? word[EN_BIT] : en_q;
    nxt_sel = is_cfg ? word[3:0]    : sel_q;
    dec     = cal_decode(nxt_sel);
    start   = evt && nxt_en && dec.ok && !busy;
    load    = dec.long_run ? CNT_W'(DUR_LONG - 1) : CNT_W'(DUR_SHORT - 1);
  end

  cal_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .load_i  (load),
    .busy_o  (busy),
    .done_o  (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      mask_q <= '0;
      drdy_o <= 1'b0;
      upd_o  <= '0;
    end else begin
      if (evt) begin
        en_q  <= nxt_en;
        sel_q <= nxt_sel;
      end
      if (start) mask_q <= dec.mask;
      upd_o <= done ? mask_q : '0;
      if (start)     drdy_o <= 1'b1;
      else if (done) drdy_o <= 1'b0;
    end
  end

  a_r6_rise_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drdy_o) |-> $past(evt));

  a_r7_upd_with_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drdy_o) |-> (upd_o != '0));

  a_r7_upd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o != '0) |=> (upd_o == '0));

  a_r4_mask_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(upd_o) <= 2);

  a_r5_busy_tracks_drdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drdy_o == busy);

endmodule

// File: tb/cal_sequencer_bench.sv
module cal_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SCLK_HALF  = 50;
  localparam int DUR_SHORT  = 40;
  localparam int DUR_LONG   = 150;
  localparam int NVEC       = 10;

  // {addr[7:0], data[15:0], run, long, mask[3:0]}
  localparam logic [29:0] VEC [NVEC] = '{
    {8'h00, 16'hABF8, 1'b1, 1'b0, 4'b0001},  // R3 upper data bits ignored, R4 1000
    {8'h00, 16'h0014, 1'b1, 1'b0, 4'b0010},  // R4 0100
    {8'h00, 16'h0012, 1'b1, 1'b1, 4'b0100},  // R4 0010 long
    {8'h00, 16'h0011, 1'b1, 1'b0, 4'b1000},  // R4 0001
    {8'h00, 16'h001C, 1'b1, 1'b0, 4'b0011},  // R4 1100
    {8'h05, 16'h0000, 1'b1, 1'b0, 4'b0011},  // R8 re-run via other register
    {8'h3A, 16'hFFFF, 1'b1, 1'b0, 4'b0011},  // R8 again
    {8'h00, 16'h0008, 1'b0, 1'b0, 4'b0000},  // R9 enable cleared
    {8'h07, 16'h0012, 1'b0, 1'b0, 4'b0000},  // R9 stays off
    {8'h00, 16'h0016, 1'b0, 1'b0, 4'b0000}   // R10 unlisted code
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sclk_i = 1'b0;
  logic       sdi_i = 1'b0;
  logic       drdy_o;
  logic [3:0] upd_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done_run = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cal_sequencer #(.DUR_SHORT(DUR_SHORT), .DUR_LONG(DUR_LONG)) u_cal_sequencer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .sdi_i  (sdi_i),
    .drdy_o (drdy_o),
    .upd_o  (upd_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] addr, input logic [15:0] data);
    logic [23:0] w;
    w = {addr, data};
    for (int i = 23; i >= 0; i--) begin
      sdi_i = w[i];
      #(SCLK_HALF) sclk_i = 1'b1;
      #(SCLK_HALF) sclk_i = 1'b0;
    end
  endtask

  task automatic expect_run(input bit longr, input logic [3:0] mask, input string tag);
    int lat;
    int hi;
    int exp_len;
    lat = 0;
    exp_len = longr ? DUR_LONG : DUR_SHORT;
    @(negedge clk_i);
    while (!drdy_o && lat < 8) begin
      lat++;
      @(negedge clk_i);
    end
    check(drdy_o && lat <= 4, {tag, " R6 drdy rise latency"}, lat, 4);
    hi = 0;
    while (drdy_o && hi < DUR_LONG + 20) begin
      hi++;
      @(negedge clk_i);
    end
    check(hi == exp_len, {tag, " R5 drdy high cycles"}, hi, exp_len);
    check(upd_o == mask, {tag, " R4/R7 upd mask at fall"}, int'(upd_o), int'(mask));
    @(negedge clk_i);
    check(upd_o == 4'b0, {tag, " R7 upd single cycle"}, int'(upd_o), 0);
  endtask

  task automatic expect_idle(input string tag);
    bit seen;
    seen = 1'b0;
    for (int c = 0; c < DUR_LONG + 10; c++) begin
      @(negedge clk_i);
      if (drdy_o || upd_o != 4'b0) seen = 1'b1;
    end
    check(!seen, {tag, " R9/R10 no run, drdy unchanged"}, int'(seen), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(drdy_o == 1'b0, "R1 drdy reset", int'(drdy_o), 0);
    check(upd_o == 4'b0, "R1 upd reset", int'(upd_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(drdy_o == 1'b0 && upd_o == 4'b0, "R1 idle after reset", int'(drdy_o), 0);

    for (int v = 0; v < NVEC; v++) begin
      send(VEC[v][29:22], VEC[v][21:6]);
      if (VEC[v][5]) expect_run(VEC[v][4], VEC[v][3:0], $sformatf("R2 vec%0d", v));
      else           expect_idle($sformatf("vec%0d", v));
    end

    // R10 unlisted code with enable set, then R8 re-enable restarts normal run
    send(8'h00, 16'h001F);
    expect_idle("R10 code 1111");
    send(8'h00, 16'h0011);
    expect_run(1'b0, 4'b1000, "R3 re-enable");
    // R9 enable clear ignores select bits even if valid
    send(8'h00, 16'h0002);
    expect_idle("R9 disable with 0010");

    // R1 asynchronous reset mid-run
    send(8'h00, 16'h0012);
    repeat (20) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(drdy_o == 1'b0 && upd_o == 4'b0, "R1 reset during run", int'(drdy_o), 0);
    rst_ni = 1'b1;
    send(8'h09, 16'h0000);
    expect_idle("R1 enable cleared by reset");

    done_run = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done_run && cyc < 200000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done_run) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule